// File: doc/BRIEF.md
# NAND Read-Retry Mode Sequencer

This block sits on the controller side of a multi-level-cell NAND flash interface. When firmware or a recovery engine wants to re-read a page with shifted sense thresholds, it hands the block a retry mode index. The block then programs the flash's internal retry registers over a simple cycle-level bus master port. It opens parameter-setting mode with a command byte. For each vendor register it sends the register address twice as address cycles, followed by one data cycle. The data byte comes from a flattened value table held by the controller. It then applies the settings, waits for the device to finish, reads the status byte and reports pass or fail.

The value table arrives as a flat input vector in which entry k occupies bits [8k+7:8k]. Entries are grouped by mode, so mode m uses entries m*NREGS through m*NREGS+NREGS-1. Each bus strobe is held for STROBE_CYC clock cycles and is followed by at least one idle cycle. A cycle-level flash model can therefore capture every transfer on the strobe edge.

Top module: `nand_retry_seq`

## Requirements
- R1: After reset, busy, done, err, busCmd, busAle, busWe and busRe are all 0.
- R2: start is accepted only while busy is 0. The cycle after an accepted start, busy is 1. A start pulse while busy is 1 does not change the transfers issued and produces no extra done pulse. No strobe is active while busy is 0.
- R3: An accepted sequence starts with one command cycle (busCmd) carrying byte 0x36.
- R4: For register j, with j running from 0 to NREGS-1, the block issues two address cycles (busAle), both carrying that register's address, and then one data cycle (busWe). Registers are visited in the order 0xCC, 0xBF, 0xAA, 0xAB, 0xCD, 0xAD, 0xAE, 0xAF (the first NREGS of them).
- R5: The data byte for register j in mode m is value table entry m*NREGS+j, taken from bits [8(m*NREGS+j)+7 : 8(m*NREGS+j)] of valueTable.
- R6: After the data cycle of the last register, the block issues command byte 0x16.
- R7: After the 0x16 command, the block waits TWB_CYC cycles and then waits until busReady is 1. Only then does it issue command byte 0x70, followed by one read cycle (busRe) that samples busDin. No 0x70 command is issued while busReady is 0.
- R8: done is a one-cycle pulse that ends every accepted start, and busy is 1 during that cycle. On a completed sequence, err equals bit 0 of the status byte read; the other status bits are ignored.
- R9: A start with modeIdx >= modeCount, or with modeIdx >= MAX_MODES, produces done=1 and err=1 in the next cycle and no bus strobe at all.
- R10: At most one strobe is active at a time. Every strobe stays high for exactly STROBE_CYC cycles. busDout holds the transferred byte for the whole command, address or data strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| modeIdx | input | CNT_W | Requested retry mode index |
| modeCount | input | CNT_W | Number of valid modes programmed |
| valueTable | input | MAX_MODES*NREGS*8 | Flattened per-mode register byte table |
| busy | output | 1 | Sequence in progress (start through done) |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error flag, valid with done |
| busCmd | output | 1 | Command latch strobe |
| busAle | output | 1 | Address latch strobe |
| busWe | output | 1 | Data write strobe |
| busRe | output | 1 | Data read strobe |
| busDout | output | 8 | Byte driven during command, address and data strobes |
| busDin | input | 8 | Byte returned by the device during busRe |
| busReady | input | 1 | Device ready (1) / busy (0) |

## Verification
The bench runs a mode at the table's far end, where a wrong stride in the entry index reads another mode's bytes. Every table byte is distinct, so such a mix-up shows up as a wrong data byte. A status byte with upper bits set and bit 0 clear catches a design that tests the whole byte rather than the fail bit. A device that stays busy for a long time catches a sequencer that reads status on a timer instead of on ready. A fast device, ready already high, catches one that waits for a low-to-high edge and hangs. Mode indices equal to the programmed count, and above the table size, must be refused with no bus traffic. A start pulse in the middle of a run must neither restart nor append a second sequence; a design that did would log extra transfers and a second done.

// File: rtl/nand_retry_pkg.sv
`timescale 1ns/1ps
package nand_retry_pkg;

  localparam logic [7:0] CMD_ENTER  = 8'h36;
  localparam logic [7:0] CMD_APPLY  = 8'h16;
  localparam logic [7:0] CMD_STATUS = 8'h70;

  typedef enum logic [1:0] {OP_CMD, OP_ADDR, OP_DATA, OP_READ} opKind_t;

  typedef enum logic [2:0] {
    BS_ENTER, BS_APPLY, BS_STATUS, BS_REGADDR, BS_REGVAL
  } byteSel_t;

  typedef struct packed {
    logic     launch;
    opKind_t  kind;
    byteSel_t sel;
    logic     loadMode;
    logic     clrIdx;
    logic     incIdx;
  } ctlStb_t;

  function automatic logic [7:0] regAddrAt(input int unsigned i);
    case (i)
      0: return 8'hCC;
      1: return 8'hBF;
      2: return 8'hAA;
      3: return 8'hAB;
      4: return 8'hCD;
      5: return 8'hAD;
      6: return 8'hAE;
      7: return 8'hAF;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/nand_retry_ctrl.sv
`timescale 1ns/1ps
module nand_retry_ctrl
  import nand_retry_pkg::*;
#(
  parameter int MAX_MODES = 8,
  parameter int TWB_CYC   = 4,
  localparam int CNT_W    = $clog2(MAX_MODES + 1),
  localparam int TWB_W    = $clog2(TWB_CYC + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] modeIdx,
  input  logic [CNT_W-1:0] modeCount,
  input  logic             busReady,
  input  logic             opDone,
  input  logic             lastReg,
  input  logic             statusFail,
  output ctlStb_t          ctl,
  output logic             busy,
  output logic             done,
  output logic             err
);

  typedef enum logic [3:0] {
    S_IDLE, S_ENTER, S_ADDR_A, S_ADDR_B, S_DATA, S_APPLY,
    S_TWB, S_WAITRDY, S_STCMD, S_STRD, S_FIN
  } state_t;

  state_t           state, nxt;
  logic             pending;
  logic             rejFlag;
  logic [TWB_W-1:0] twbCnt;
  logic             inRange;

  assign inRange = (modeIdx < modeCount) && (modeIdx < CNT_W'(MAX_MODES));
  assign busy    = (state != S_IDLE);

  always_comb begin
    ctl  = '0;
    nxt  = state;
    done = 1'b0;
    err  = 1'b0;
    case (state)
      S_IDLE: begin
        if (start) begin
          if (inRange) begin
            ctl.loadMode = 1'b1;
            ctl.clrIdx   = 1'b1;
            nxt          = S_ENTER;
          end else begin
            nxt = S_FIN;
          end
        end
      end
      S_ENTER: begin
        ctl.kind = OP_CMD; ctl.sel = BS_ENTER; ctl.launch = !pending;
        if (opDone) nxt = S_ADDR_A;
      end
      S_ADDR_A: begin
        ctl.kind = OP_ADDR; ctl.sel = BS_REGADDR; ctl.launch = !pending;
        if (opDone) nxt = S_ADDR_B;
      end
      S_ADDR_B: begin
        ctl.kind = OP_ADDR; ctl.sel = BS_REGADDR; ctl.launch = !pending;
        if (opDone) nxt = S_DATA;
      end
      S_DATA: begin
        ctl.kind = OP_DATA; ctl.sel = BS_REGVAL; ctl.launch = !pending;
        if (opDone) begin
          if (lastReg) nxt = S_APPLY;
          else begin
            ctl.incIdx = 1'b1;
            nxt        = S_ADDR_A;
          end
        end
      end
      S_APPLY: begin
        ctl.kind = OP_CMD; ctl.sel = BS_APPLY; ctl.launch = !pending;
        if (opDone) nxt = S_TWB;
      end
      S_TWB:     if (twbCnt == '0) nxt = S_WAITRDY;
      S_WAITRDY: if (busReady) nxt = S_STCMD;
      S_STCMD: begin
        ctl.kind = OP_CMD; ctl.sel = BS_STATUS; ctl.launch = !pending;
        if (opDone) nxt = S_STRD;
      end
      S_STRD: begin
        ctl.kind = OP_READ; ctl.sel = BS_STATUS; ctl.launch = !pending;
        if (opDone) nxt = S_FIN;
      end
      S_FIN: begin
        done = 1'b1;
        err  = rejFlag | statusFail;
        nxt  = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      pending <= 1'b0;
      rejFlag <= 1'b0;
      twbCnt  <= '0;
    end else begin
      state <= nxt;
      if (ctl.launch)  pending <= 1'b1;
      else if (opDone) pending <= 1'b0;
      if (state == S_IDLE && start) rejFlag <= !inRange;
      if (state == S_APPLY && opDone) twbCnt <= TWB_W'(TWB_CYC - 1);
      else if (state == S_TWB && twbCnt != '0) twbCnt <= twbCnt - 1'b1;
    end
  end

endmodule

// File: rtl/nand_retry_dpath.sv
`timescale 1ns/1ps
module nand_retry_dpath
  import nand_retry_pkg::*;
#(
  parameter int MAX_MODES  = 8,
  parameter int NREGS      = 8,
  parameter int STROBE_CYC = 3,
  localparam int CNT_W     = $clog2(MAX_MODES + 1),
  localparam int MODE_W    = (MAX_MODES > 1) ? $clog2(MAX_MODES) : 1,
  localparam int IDX_W     = (NREGS > 1) ? $clog2(NREGS) : 1,
  localparam int ENTRIES   = MAX_MODES * NREGS,
  localparam int ENT_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int TBL_W     = ENTRIES * 8,
  localparam int TMR_W     = $clog2(STROBE_CYC + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStb_t          ctl,
  input  logic [CNT_W-1:0] modeIdx,
  input  logic [TBL_W-1:0] valueTable,
  input  logic [7:0]       busDin,
  output logic             busCmd,
  output logic             busAle,
  output logic             busWe,
  output logic             busRe,
  output logic [7:0]       busDout,
  output logic             opDone,
  output logic             lastReg,
  output logic             statusFail
);

  typedef enum logic [1:0] {P_IDLE, P_STROBE, P_GAP} phase_t;

  phase_t            phase;
  logic [TMR_W-1:0]  timer;
  opKind_t           curKind;
  logic [7:0]        curByte;
  logic [7:0]        selByte;
  logic [MODE_W-1:0] modeReg;
  logic [IDX_W-1:0]  regIdx;
  logic [ENT_W-1:0]  entryIdx;
  logic [7:0]        regAddrTab [NREGS];
  logic              strobeOn;

  for (genvar g = 0; g < NREGS; g++) begin : g_addr
    assign regAddrTab[g] = regAddrAt(g);
  end

  assign entryIdx = ENT_W'(modeReg) * ENT_W'(NREGS) + ENT_W'(regIdx);
  assign lastReg  = (regIdx == IDX_W'(NREGS - 1));

  always_comb begin
    case (ctl.sel)
      BS_ENTER:   selByte = CMD_ENTER;
      BS_APPLY:   selByte = CMD_APPLY;
      BS_STATUS:  selByte = CMD_STATUS;
      BS_REGADDR: selByte = regAddrTab[regIdx];
      BS_REGVAL:  selByte = valueTable[{entryIdx, 3'b000} +: 8];
      default:    selByte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase      <= P_IDLE;
      timer      <= '0;
      curKind    <= OP_CMD;
      curByte    <= '0;
      modeReg    <= '0;
      regIdx     <= '0;
      statusFail <= 1'b0;
    end else begin
      if (ctl.loadMode) begin
        modeReg    <= modeIdx[MODE_W-1:0];
        statusFail <= 1'b0;
      end
      if (ctl.clrIdx)      regIdx <= '0;
      else if (ctl.incIdx) regIdx <= regIdx + 1'b1;

      case (phase)
        P_IDLE: begin
          if (ctl.launch) begin
            phase   <= P_STROBE;
            timer   <= TMR_W'(STROBE_CYC - 1);
            curKind <= ctl.kind;
            curByte <= selByte;
          end
        end
        P_STROBE: begin
          if (timer == '0) begin
            phase <= P_GAP;
            if (curKind == OP_READ) statusFail <= busDin[0];
          end else begin
            timer <= timer - 1'b1;
          end
        end
        default: phase <= P_IDLE;
      endcase
    end
  end

  assign strobeOn = (phase == P_STROBE);
  assign opDone   = (phase == P_GAP);
  assign busCmd   = strobeOn && (curKind == OP_CMD);
  assign busAle   = strobeOn && (curKind == OP_ADDR);
  assign busWe    = strobeOn && (curKind == OP_DATA);
  assign busRe    = strobeOn && (curKind == OP_READ);
  assign busDout  = (strobeOn && curKind != OP_READ) ? curByte : 8'h00;

endmodule

// File: rtl/nand_retry_seq.sv
`timescale 1ns/1ps
module nand_retry_seq
  import nand_retry_pkg::*;
#(
  parameter int MAX_MODES  = 8,
  parameter int NREGS      = 8,
  parameter int STROBE_CYC = 3,
  parameter int TWB_CYC    = 4,
  localparam int CNT_W     = $clog2(MAX_MODES + 1),
  localparam int TBL_W     = MAX_MODES * NREGS * 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] modeIdx,
  input  logic [CNT_W-1:0] modeCount,
  input  logic [TBL_W-1:0] valueTable,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             busCmd,
  output logic             busAle,
  output logic             busWe,
  output logic             busRe,
  output logic [7:0]       busDout,
  input  logic [7:0]       busDin,
  input  logic             busReady
);

  ctlStb_t ctl;
  logic    opDone;
  logic    lastReg;
  logic    statusFail;

  nand_retry_ctrl #(
    .MAX_MODES (MAX_MODES),
    .TWB_CYC   (TWB_CYC)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .modeIdx    (modeIdx),
    .modeCount  (modeCount),
    .busReady   (busReady),
    .opDone     (opDone),
    .lastReg    (lastReg),
    .statusFail (statusFail),
    .ctl        (ctl),
    .busy       (busy),
    .done       (done),
    .err        (err)
  );

  nand_retry_dpath #(
    .MAX_MODES  (MAX_MODES),
    .NREGS      (NREGS),
    .STROBE_CYC (STROBE_CYC)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .modeIdx    (modeIdx),
    .valueTable (valueTable),
    .busDin     (busDin),
    .busCmd     (busCmd),
    .busAle     (busAle),
    .busWe      (busWe),
    .busRe      (busRe),
    .busDout    (busDout),
    .opDone     (opDone),
    .lastReg    (lastReg),
    .statusFail (statusFail)
  );

endmodule

// File: rtl/nand_retry_seq_chk.sv
`timescale 1ns/1ps
module nand_retry_seq_chk #(
  parameter int MAX_MODES  = 8,
  parameter int STROBE_CYC = 3,
  localparam int CNT_W     = $clog2(MAX_MODES + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [CNT_W-1:0] modeIdx,
  input logic [CNT_W-1:0] modeCount,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic             busCmd,
  input logic             busAle,
  input logic             busWe,
  input logic             busRe,
  input logic [7:0]       busDout,
  input logic             busReady
);

  logic       anyStb;
  logic [7:0] hiCnt;

  assign anyStb = busCmd | busAle | busWe | busRe;

  always_ff @(posedge clk) begin
    if (!rstN)                hiCnt <= '0;
    else if (!anyStb)         hiCnt <= '0;
    else if (hiCnt != 8'hFF)  hiCnt <= hiCnt + 1'b1;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busCmd, busAle, busWe, busRe}));  // R10

  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    (!anyStb && $past(anyStb)) |-> (hiCnt == 8'(STROBE_CYC)));  // R10

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !anyStb);  // R2

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);  // R2

  AST_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && (modeIdx >= modeCount || modeIdx >= CNT_W'(MAX_MODES)))
      |=> (done && err && !anyStb));  // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R8

  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);  // R8

  AST_STATUS_READY: assert property (@(posedge clk) disable iff (!rstN)
    (busCmd && busDout == 8'h70) |-> busReady);  // R7

endmodule

bind nand_retry_seq nand_retry_seq_chk #(
  .MAX_MODES  (MAX_MODES),
  .STROBE_CYC (STROBE_CYC)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .modeIdx   (modeIdx),
  .modeCount (modeCount),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .busCmd    (busCmd),
  .busAle    (busAle),
  .busWe     (busWe),
  .busRe     (busRe),
  .busDout   (busDout),
  .busReady  (busReady)
);

// File: tb/tb_nand_retry_seq.sv
`timescale 1ns/1ps
module tb_nand_retry_seq;

  localparam int MAX_MODES  = 8;
  localparam int NREGS      = 8;
  localparam int STROBE_CYC = 3;
  localparam int TWB_CYC    = 4;
  localparam int CNT_W      = $clog2(MAX_MODES + 1);
  localparam int TBL_W      = MAX_MODES * NREGS * 8;
  localparam int SEQ_LEN    = 3 * NREGS + 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [CNT_W-1:0] modeIdx = '0;
  logic [CNT_W-1:0] modeCount = '0;
  logic [TBL_W-1:0] valueTable;
  logic             busy, done, err;
  logic             busCmd, busAle, busWe, busRe;
  logic [7:0]       busDout;
  logic [7:0]       busDin;
  logic             busReady = 1'b1;
  logic [7:0]       statusVal = 8'h00;

  int tests = 0;
  int fails = 0;

  // device model state
  int  logKind [64];
  int  logByte [64];
  int  logN = 0;
  int  cyc = 0;
  int  hiLen = 0;
  int  widthBad = 0;
  int  lowCyc = 0;
  int  rdyTimer = 0;
  int  rdyRiseCyc = -1;
  int  stat70Cyc = -1;
  bit  stat70Rdy = 1'b1;
  logic pCmd = 0, pAle = 0, pWe = 0, pRe = 0;

  always #5 clk = ~clk;

  nand_retry_seq #(
    .MAX_MODES(MAX_MODES), .NREGS(NREGS),
    .STROBE_CYC(STROBE_CYC), .TWB_CYC(TWB_CYC)
  ) dut (
    .clk(clk), .rstN(rstN), .start(start), .modeIdx(modeIdx),
    .modeCount(modeCount), .valueTable(valueTable),
    .busy(busy), .done(done), .err(err),
    .busCmd(busCmd), .busAle(busAle), .busWe(busWe), .busRe(busRe),
    .busDout(busDout), .busDin(busDin), .busReady(busReady)
  );

  assign busDin = busRe ? statusVal : 8'h00;

  function automatic logic [7:0] tblByte(input int k);
    return 8'((k * 29 + 7) % 256);
  endfunction

  function automatic logic [7:0] refAddr(input int j);
    logic [7:0] t [8] = '{8'hCC, 8'hBF, 8'hAA, 8'hAB, 8'hCD, 8'hAD, 8'hAE, 8'hAF};
    return t[j];
  endfunction

  initial begin
    for (int k = 0; k < MAX_MODES * NREGS; k++) valueTable[k*8 +: 8] = tblByte(k);
  end

  task automatic logEvent(input int kind, input int b);
    if (logN < 64) begin
      logKind[logN] = kind;
      logByte[logN] = b;
    end
    logN++;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!busReady) begin
      if (rdyTimer <= 1) begin
        busReady = 1'b1;
        rdyRiseCyc = cyc;
      end else rdyTimer--;
    end
    if (busCmd && !pCmd) begin
      logEvent(0, busDout);
      if (busDout == 8'h16 && lowCyc > 0) begin
        busReady = 1'b0;
        rdyTimer = lowCyc;
      end
      if (busDout == 8'h70) begin
        stat70Cyc = cyc;
        stat70Rdy = busReady;
      end
    end
    if (busAle && !pAle) logEvent(1, busDout);
    if (busWe && !pWe)   logEvent(2, busDout);
    if (busRe && !pRe)   logEvent(3, 0);
    if (busCmd | busAle | busWe | busRe) hiLen++;
    else if (hiLen != 0) begin
      if (hiLen != STROBE_CYC) widthBad++;
      hiLen = 0;
    end
    pCmd = busCmd; pAle = busAle; pWe = busWe; pRe = busRe;
  end

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clearLog();
    logN = 0; widthBad = 0; stat70Cyc = -1; stat70Rdy = 1'b1; rdyRiseCyc = -1;
  endtask

  // Pulse start and wait for done; returns err and number of done pulses.
  task automatic runSeq(input int mode, input int count, input int midStart,
                        output logic gotErr, output int doneCnt);
    bit finished = 0;
    modeIdx = CNT_W'(mode);
    modeCount = CNT_W'(count);
    doneCnt = 0;
    gotErr = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R2 busy after start", busy == 1'b1, busy, 1);
    for (int i = 0; i < 3000 && !finished; i++) begin
      if (i == 20 && midStart >= 0) begin
        modeIdx = CNT_W'(midStart);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        modeIdx = CNT_W'(mode);
      end
      if (done) begin
        doneCnt++;
        gotErr = err;
        chk("R8 busy with done", busy == 1'b1, busy, 1);
        finished = 1;
      end else @(negedge clk);
    end
    @(negedge clk);
    chk("R8 done is one cycle", done == 1'b0, done, 0);
    chk("R8 idle after done", busy == 1'b0, busy, 0);
  endtask

  task automatic checkLog(input int mode);
    int badEnter = 0, badAddr = 0, badData = 0, badApply = 0, badTail = 0;
    chk("R4 transfer count", logN == SEQ_LEN, logN, SEQ_LEN);
    for (int i = 0; i < SEQ_LEN && i < logN; i++) begin
      if (i == 0) begin
        if (logKind[i] != 0 || logByte[i] != 8'h36) badEnter++;
      end else if (i <= 3 * NREGS) begin
        int j = (i - 1) / 3;
        int p = (i - 1) % 3;
        if (p < 2) begin
          if (logKind[i] != 1 || logByte[i] != int'(refAddr(j))) badAddr++;
        end else begin
          if (logKind[i] != 2 || logByte[i] != int'(tblByte(mode * NREGS + j))) badData++;
        end
      end else if (i == 3 * NREGS + 1) begin
        if (logKind[i] != 0 || logByte[i] != 8'h16) badApply++;
      end else if (i == 3 * NREGS + 2) begin
        if (logKind[i] != 0 || logByte[i] != 8'h70) badTail++;
      end else begin
        if (logKind[i] != 3) badTail++;
      end
    end
    chk("R3 enter command 0x36", badEnter == 0, badEnter, 0);
    chk("R4 register address pairs", badAddr == 0, badAddr, 0);
    chk("R5 mode data bytes", badData == 0, badData, 0);
    chk("R6 apply command 0x16", badApply == 0, badApply, 0);
    chk("R7 status command and read", badTail == 0, badTail, 0);
    chk("R10 strobe width", widthBad == 0, widthBad, 0);
  endtask

  task automatic t_reset();
    chk("R1 busy at reset", busy == 1'b0, busy, 0);
    chk("R1 done at reset", done == 1'b0, done, 0);
    chk("R1 err at reset", err == 1'b0, err, 0);
    chk("R1 strobes at reset", {busCmd, busAle, busWe, busRe} == 4'b0,
        {busCmd, busAle, busWe, busRe}, 0);
  endtask

  task automatic t_mode(input int mode, input int count, input logic [7:0] st,
                        input int low, input logic expErr);
    logic e; int dc;
    clearLog();
    statusVal = st;
    lowCyc = low;
    runSeq(mode, count, -1, e, dc);
    chk("R8 one done pulse", dc == 1, dc, 1);
    chk("R8 err follows status bit 0", e == expErr, e, expErr);
    checkLog(mode);
    chk("R7 status read with ready high", stat70Rdy == 1'b1, stat70Rdy, 1);
    if (low > 0)
      chk("R7 status after ready rise", stat70Cyc > rdyRiseCyc && rdyRiseCyc > 0,
          stat70Cyc, rdyRiseCyc + 1);
  endtask

  task automatic t_reject(input int mode, input int count);
    logic e; int dc;
    clearLog();
    runSeq(mode, count, -1, e, dc);
    chk("R9 reject done", dc == 1, dc, 1);
    chk("R9 reject err", e == 1'b1, e, 1);
    chk("R9 no bus traffic", logN == 0, logN, 0);
  endtask

  task automatic t_startBusy();
    logic e; int dc;
    clearLog();
    statusVal = 8'h00;
    lowCyc = 5;
    runSeq(2, 8, 6, e, dc);
    repeat (60) @(negedge clk);
    chk("R2 single done for mid start", dc == 1 && done == 1'b0, dc, 1);
    chk("R2 mid start ignored", logN == SEQ_LEN, logN, SEQ_LEN);
    checkLog(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_mode(0, 8, 8'hC0, 10, 1'b0);
    t_mode(4, 5, 8'h01, 0, 1'b1);
    t_mode(7, 8, 8'hFE, 60, 1'b0);
    t_reject(5, 5);
    t_reject(9, 10);
    t_startBusy();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule